// File: doc/BRIEF.md
# Shared Interrupt Line Controller

This block sits on the card side of a removable I/O card and decides when the card pulls its interrupt pin low. Up to seven I/O functions each raise a level request. A request counts only when its own enable bit and the card-wide master enable are both set. The surviving requests are OR-ed into one registered request. A pin drive is then issued only when the current bus mode allows it.

The interrupt pin is shared with data line 1 in the 4-bit mode. For that reason the drive is qualified by mode:
- In SPI mode it is gated by chip select.
- In 1-bit mode it is free.
- In 4-bit mode it is allowed only while the bus engine flags an interrupt window and the data engine does not own data line 1.

A pending vector reports the raw requests of the implemented functions to the register interface. The enable bits are held here, are written through a simple strobe, and can be read back.

Top module: `shared_irq_ctrl`

## Requirements
- R1: The interrupt is level-sensitive. `irq_drive` stays high for as long as an enabled source stays asserted. It falls within one clock edge after the last enabled source drops.
- R2: A function's request can cause a drive only when both its bit in `en_func` and `en_master` are 1.
- R3: Bit i of `pending` equals `func_irq[i]` for each implemented function, whatever the enable bits are.
- R4: A function whose bit in `IMPL_MASK` is 0 reads 0 in both `pending` and `en_func`, and it never causes a drive. The default mask leaves function 7 (bit 6) unimplemented.
- R5: `en_func` and `en_master` are 0 after `rst_n` low. They are also cleared on the edge where `io_rst` is 1.
- R6: With `bus_mode` = 2'b00 (SPI), `irq_drive` is 1 only while `cs_n` is 0.
- R7: With `bus_mode` = 2'b01 (1-bit), `irq_drive` follows the registered request, whatever `cs_n`, `irq_win` and `dat1_busy` are.
- R8: With `bus_mode` = 2'b10 (4-bit), `irq_drive` is 1 only while `irq_win` is 1 and `dat1_busy` is 0. `dat1_busy` overrides the window.
- R9: With `bus_mode` = 2'b11 (reserved), `irq_drive` is always 0.
- R10: Any single enabled source among several is enough to drive the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| io_rst | input | 1 | Synchronous I/O reset, clears enables |
| func_irq | input | NFUNC | Level requests; bit i is function i+1 |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wr_func | input | NFUNC | Per-function enable write data |
| en_wr_master | input | 1 | Master enable write data |
| bus_mode | input | 2 | 00 SPI, 01 1-bit, 10 4-bit, 11 reserved |
| cs_n | input | 1 | Chip select, active low (SPI mode) |
| irq_win | input | 1 | Interrupt window valid, from the bus engine |
| dat1_busy | input | 1 | Data engine owns data line 1 |
| en_func | output | NFUNC | Per-function enable readback |
| en_master | output | 1 | Master enable readback |
| pending | output | NFUNC | Raw requests of implemented functions |
| irq_drive | output | 1 | 1 requests that the pin be pulled low |

## Verification
The table of vectors covers several cases:
- A single enabled source, and a missing function enable or a missing master enable, which shows whether both gates are applied.
- Two sources where only one is enabled, which shows the OR.
- A request from the unimplemented function.
- Each bus mode, with chip select, window and data ownership varied one at a time. In 4-bit mode this shows that ownership of data line 1 outranks the window. In 1-bit mode it shows that the qualifiers are ignored.

Directed tests cover the reset values, `pending` under all enables off, the enable readback mask, clearing by I/O reset, and the hold and one-edge release of a level request.

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl #(
  parameter int NFUNC = 7,
  parameter logic [NFUNC-1:0] IMPL_MASK = 7'b0111111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_rst,
  input  logic [NFUNC-1:0] func_irq,
  input  logic             en_wr,
  input  logic [NFUNC-1:0] en_wr_func,
  input  logic             en_wr_master,
  input  logic [1:0]       bus_mode,
  input  logic             cs_n,
  input  logic             irq_win,
  input  logic             dat1_busy,
  output logic [NFUNC-1:0] en_func,
  output logic             en_master,
  output logic [NFUNC-1:0] pending,
  output logic             irq_drive
);
  localparam logic [1:0] M_SPI  = 2'b00;
  localparam logic [1:0] M_ONE  = 2'b01;
  localparam logic [1:0] M_FOUR = 2'b10;

  logic [NFUNC-1:0] en_func_q;
  logic             en_master_q;
  logic             req_q;
  logic [NFUNC-1:0] gated;
  logic             mode_ok;

  assign gated   = func_irq & en_func_q & IMPL_MASK & {NFUNC{en_master_q}};
  assign pending = func_irq & IMPL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_func_q   <= '0;
      en_master_q <= 1'b0;
      req_q       <= 1'b0;
    end else if (io_rst) begin
      en_func_q   <= '0;
      en_master_q <= 1'b0;
      req_q       <= 1'b0;
    end else begin
      if (en_wr) begin
        en_func_q   <= en_wr_func & IMPL_MASK;
        en_master_q <= en_wr_master;
      end
      req_q <= |gated;
    end
  end

  always_comb begin
    case (bus_mode)
      M_SPI:   mode_ok = !cs_n;
      M_ONE:   mode_ok = 1'b1;
      M_FOUR:  mode_ok = irq_win && !dat1_busy;
      default: mode_ok = 1'b0;
    endcase
  end

  assign irq_drive = req_q && mode_ok;
  assign en_func   = en_func_q;
  assign en_master = en_master_q;

  p_level_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(io_rst) && $past(|gated) && bus_mode == M_ONE) |-> irq_drive);

  p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|gated) |-> !irq_drive);

  p_spi_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == M_SPI && cs_n) |-> !irq_drive);

  p_dat1_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == M_FOUR && (dat1_busy || !irq_win)) |-> !irq_drive);

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == 2'b11) |-> !irq_drive);

  p_io_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io_rst |=> (en_func == '0 && !en_master));

  p_unimpl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending | en_func) & ~IMPL_MASK) == '0);
endmodule

// File: tb/sim_shared_irq_ctrl.sv
module sim_shared_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_rst = 1'b0;
  logic [6:0] func_irq = '0;
  logic en_wr = 1'b0;
  logic [6:0] en_wr_func = '0;
  logic en_wr_master = 1'b0;
  logic [1:0] bus_mode = 2'b01;
  logic cs_n = 1'b1;
  logic irq_win = 1'b0;
  logic dat1_busy = 1'b0;
  logic [6:0] en_func;
  logic en_master;
  logic [6:0] pending;
  logic irq_drive;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  shared_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .io_rst(io_rst), .func_irq(func_irq),
    .en_wr(en_wr), .en_wr_func(en_wr_func), .en_wr_master(en_wr_master),
    .bus_mode(bus_mode), .cs_n(cs_n), .irq_win(irq_win), .dat1_busy(dat1_busy),
    .en_func(en_func), .en_master(en_master), .pending(pending), .irq_drive(irq_drive));

  // {irq[20:14], en[13:7], master[6], mode[5:4], cs_n[3], win[2], busy[1], expected drive[0]}
  localparam int NV = 15;
  localparam logic [20:0] VEC [0:NV-1] = '{
    {7'b0000001, 7'b0000001, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1},
    {7'b0000001, 7'b0000001, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0},
    {7'b0000001, 7'b0000010, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0},
    {7'b0100100, 7'b0000100, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1},
    {7'b0100100, 7'b0100000, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1},
    {7'b1000000, 7'b1000000, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0},
    {7'b0000010, 7'b0000010, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'b0000010, 7'b0000010, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1},
    {7'b0000010, 7'b0000010, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0},
    {7'b0001000, 7'b0001000, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1},
    {7'b0001000, 7'b0001000, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0},
    {7'b0001000, 7'b0001000, 1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0},
    {7'b0001000, 7'b0001000, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0},
    {7'b0010000, 7'b0000000, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0},
    {7'b0010000, 7'b0010000, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_en(input logic [6:0] f, input logic m);
    @(negedge clk);
    en_wr = 1'b1; en_wr_func = f; en_wr_master = m;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5 reset state
    check("R5 reset en_func", {1'b0, en_func}, 8'h00);
    check("R5 reset en_master", {7'b0, en_master}, 8'h00);
    check("R5 reset drive", {7'b0, irq_drive}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      write_en(VEC[i][13:7], VEC[i][6]);
      func_irq = VEC[i][20:14]; bus_mode = VEC[i][5:4]; cs_n = VEC[i][3];
      irq_win = VEC[i][2]; dat1_busy = VEC[i][1];
      @(negedge clk);
      check($sformatf("R2/R4/R6/R7/R8/R9/R10 vector %0d", i), {7'b0, irq_drive}, {7'b0, VEC[i][0]});
      func_irq = '0;
      @(negedge clk);
    end

    // R3 pending independent of enables
    write_en(7'b0, 1'b0);
    func_irq = 7'b1111111; bus_mode = 2'b01;
    @(negedge clk);
    check("R3 pending", {1'b0, pending}, 8'h3F);
    check("R3 no drive with enables off", {7'b0, irq_drive}, 8'h00);

    // R4 readback of unimplemented enable
    write_en(7'b1111111, 1'b1);
    check("R4 en_func mask", {1'b0, en_func}, 8'h3F);
    check("R4 pending mask", {1'b0, pending}, 8'h3F);

    // R1 hold and release
    func_irq = 7'b0000001;
    repeat (4) @(negedge clk);
    check("R1 held", {7'b0, irq_drive}, 8'h01);
    func_irq = '0;
    #1;
    check("R1 still registered before edge", {7'b0, irq_drive}, 8'h01);
    @(negedge clk);
    check("R1 released", {7'b0, irq_drive}, 8'h00);

    // R5 io reset clears enables
    @(negedge clk);
    io_rst = 1'b1;
    @(negedge clk);
    io_rst = 1'b0;
    check("R5 io_rst en_func", {1'b0, en_func}, 8'h00);
    check("R5 io_rst en_master", {7'b0, en_master}, 8'h00);
    func_irq = 7'b0000001;
    @(negedge clk);
    check("R5 no drive after io_rst", {7'b0, irq_drive}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule